// File: doc/BRIEF.md
# Packet Concatenation Segmenter

This block sits at the head of one virtual output queue of an input-queued switch. It takes variable-length packets from the queue as a descriptor stream, which carries one length per packet, and a byte stream that carries the payload. It joins back-to-back packets into a single internal group and cuts the group into fixed-size segments, one per time slot. No padding is placed between the packets of a group. Only the final segment of the group is filled with zero bytes up to the segment boundary.

A programmable threshold caps how many packets one group may hold. When a group reaches that cap, it closes even if more packets are waiting, and those packets start a new group at the next opportunity. A group also closes when no further descriptor is waiting at the moment the last byte of a packet is taken. Segments leave on a valid/ready interface with a last-of-group flag and the padding count of that segment. When a group ends, the block reports the group's segment count and packet count for the scheduler. It also keeps cumulative counters of padding bytes and forwarded bytes, so that the wastage ratio can be computed.

Top module: `pcat_segmenter`

## Requirements
- R1: A segment holds SEG_BYTES bytes (default 64; the value must be at least 20). Accepted payload bytes fill it in arrival order, and the k-th byte of a segment appears at seg_data bits [8k+7:8k].
- R2: The packets of a group are packed back to back with no gap. A group of T payload bytes leaves as exactly ceil(T / SEG_BYTES) segments.
- R3: Only the final segment of a group has seg_last = 1. Every other segment is completely filled and has seg_pad = 0. The final segment has seg_pad = SEG_BYTES * segments − T, and its unused byte lanes are zero.
- R4: A group holds at most cfg_max_pkts packets, and a value of 0 acts as 1. When the cap is reached, the group closes even though a further descriptor is waiting.
- R5: If hdr_valid is low in the cycle that the last byte of a packet is accepted, the group closes with that packet.
- R6: With cfg_max_pkts = 1, each packet is padded on its own. Packets of 80 and 150 bytes then take 5 segments with 90 padding bytes. With cfg_max_pkts = 2, the same two packets take 4 segments with 26 padding bytes.
- R7: While seg_valid is high and seg_ready is low, the segment's data, last flag and padding count stay unchanged. While a segment waits, no descriptor or payload byte is accepted.
- R8: One cycle after the handshake of a final segment, grp_done is high for one cycle. At the same time, grp_segs carries the group's segment count and grp_pkts carries its packet count.
- R9: On each segment handshake, fwd_total grows by SEG_BYTES and pad_total grows by that segment's seg_pad. Both new values are visible in the next cycle.
- R10: After reset, seg_valid, dat_ready and grp_done are 0, and pad_total and fwd_total are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_max_pkts | input | CNT_W | Maximum number of packets per group (0 acts as 1) |
| hdr_valid | input | 1 | A packet descriptor is waiting at the queue head |
| hdr_len | input | LEN_W | Length of the waiting packet in bytes (at least 1) |
| hdr_ready | output | 1 | Descriptor accepted when high together with hdr_valid |
| dat_valid | input | 1 | A payload byte is offered |
| dat_byte | input | 8 | Payload byte |
| dat_ready | output | 1 | Payload byte accepted when high together with dat_valid |
| seg_valid | output | 1 | A segment is offered |
| seg_data | output | 8*SEG_BYTES | Segment bytes, byte 0 in the low lane |
| seg_last | output | 1 | Final segment of the current group |
| seg_pad | output | FILL_W | Padding bytes in this segment |
| seg_ready | input | 1 | Downstream takes the segment |
| grp_done | output | 1 | One-cycle pulse after a group's final segment has left |
| grp_segs | output | GSEG_W | Segment count of the group just finished |
| grp_pkts | output | CNT_W | Packet count of the group just finished |
| pad_total | output | STAT_W | Cumulative padding bytes sent |
| fwd_total | output | STAT_W | Cumulative bytes sent (payload plus padding) |

## Verification
Descriptor and payload handshakes take effect at the same edge that samples them. A segment becomes valid one cycle after the byte that fills it or closes its group. grp_done, grp_segs and grp_pkts follow the final segment's handshake by exactly one cycle, and the two totals also change one cycle after each handshake. The bench drives its inputs on the falling edge and samples shortly after it. It records every handshake seen in a cycle and expects grp_done at exactly the next sample point. It compares the totals only once the queue has drained. Sweeps over thresholds and length mixes, with and without backpressure and input gaps, compute every segment's bytes, its flags and each group's counts from the packet lengths alone.

// File: rtl/pcat_pkg.sv
package pcat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2
    } grp_state_e;

    // number of whole segments needed for a byte count
    function automatic int unsigned segs_for(input int unsigned bytes, input int unsigned seg);
        return (bytes + seg - 1) / seg;
    endfunction

endpackage

// File: rtl/pcat_seg_buf.sv
module pcat_seg_buf #(
    parameter int SEG_BYTES = 64,
    parameter int FILL_W    = $clog2(SEG_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [7:0]             wr_byte,
    input  logic                   clr,
    output logic [FILL_W-1:0]      fill,
    output logic [SEG_BYTES*8-1:0] data
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(SEG_BYTES);

    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            fill_q <= '0;
        else if (wr_en)
            fill_q <= fill_q + FILL_W'(1);
    end

    generate
        for (genvar i = 0; i < SEG_BYTES; i++) begin : g_lane
            logic [7:0] lane_q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    lane_q <= 8'h00;
                else if (wr_en && fill_q == FILL_W'(i))
                    lane_q <= wr_byte;
            end
            assign data[i*8 +: 8] = lane_q;
        end
    endgenerate

    assign fill = fill_q;

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FULL);

    // R1
    no_write_past_end_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> fill_q < FULL);

endmodule

// File: rtl/pcat_grp_ctrl.sv
module pcat_grp_ctrl
    import pcat_pkg::*;
#(
    parameter int SEG_BYTES = 64,
    parameter int LEN_W     = 11,
    parameter int CNT_W     = 4,
    parameter int FILL_W    = $clog2(SEG_BYTES + 1),
    parameter int GSEG_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_max_pkts,
    input  logic              hdr_valid,
    input  logic [LEN_W-1:0]  hdr_len,
    output logic              hdr_ready,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [FILL_W-1:0] fill,
    output logic              wr_en,
    output logic              clr,
    output logic              seg_valid,
    output logic              seg_last,
    output logic [FILL_W-1:0] seg_pad,
    input  logic              seg_ready,
    output logic              grp_done,
    output logic [GSEG_W-1:0] grp_segs,
    output logic [CNT_W-1:0]  grp_pkts
);
    localparam logic [FILL_W-1:0] FULL     = FILL_W'(SEG_BYTES);
    localparam logic [FILL_W-1:0] LAST_POS = FILL_W'(SEG_BYTES - 1);

    typedef struct packed {
        logic [GSEG_W-1:0] segs;
        logic [CNT_W-1:0]  pkts;
    } grp_rpt_t;

    grp_state_e       st_q;
    logic [LEN_W-1:0] left_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic             last_q;
    logic [GSEG_W-1:0] segs_q;
    logic             done_q;
    grp_rpt_t         rpt_q;

    logic pkt_end, full_next, cont;
    logic [CNT_W-1:0] thr_eff;

    assign pkt_end   = (left_q == LEN_W'(1));
    assign full_next = (fill == LAST_POS);
    assign cont      = hdr_valid && (cnt_q < thr_q);
    assign thr_eff   = (cfg_max_pkts == '0) ? CNT_W'(1) : cfg_max_pkts;

    assign wr_en     = (st_q == ST_FILL) && dat_valid;
    assign dat_ready = (st_q == ST_FILL);
    assign hdr_ready = (st_q == ST_IDLE) || (wr_en && pkt_end && cont);
    assign seg_valid = (st_q == ST_SEND);
    assign seg_last  = last_q;
    assign seg_pad   = last_q ? (FULL - fill) : '0;
    assign clr       = seg_valid && seg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            left_q <= '0;
            cnt_q  <= '0;
            thr_q  <= CNT_W'(1);
            last_q <= 1'b0;
            segs_q <= '0;
            done_q <= 1'b0;
            rpt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (hdr_valid) begin
                        left_q <= hdr_len;
                        cnt_q  <= CNT_W'(1);
                        thr_q  <= thr_eff;
                        segs_q <= '0;
                        last_q <= 1'b0;
                        st_q   <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (dat_valid) begin
                        if (pkt_end) begin
                            if (cont) begin
                                left_q <= hdr_len;
                                cnt_q  <= cnt_q + CNT_W'(1);
                                if (full_next) begin
                                    last_q <= 1'b0;
                                    st_q   <= ST_SEND;
                                end
                            end else begin
                                left_q <= '0;
                                last_q <= 1'b1;
                                st_q   <= ST_SEND;
                            end
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                            if (full_next) begin
                                last_q <= 1'b0;
                                st_q   <= ST_SEND;
                            end
                        end
                    end
                end
                ST_SEND: begin
                    if (seg_ready) begin
                        segs_q <= segs_q + GSEG_W'(1);
                        if (last_q) begin
                            done_q     <= 1'b1;
                            rpt_q.segs <= segs_q + GSEG_W'(1);
                            rpt_q.pkts <= cnt_q;
                            st_q       <= ST_IDLE;
                        end else begin
                            st_q <= ST_FILL;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign grp_done = done_q;
    assign grp_segs = rpt_q.segs;
    assign grp_pkts = rpt_q.pkts;

    // R3
    full_unless_last_chk: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_last |-> fill == FULL);

    // R4
    grp_cap_chk: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_FILL |-> cnt_q <= thr_q);

    // R5
    empty_close_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && pkt_end && !hdr_valid |=> seg_valid && seg_last);

    // R7
    seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_last) && $stable(seg_pad));

    // R7
    no_intake_while_send_chk: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> !hdr_ready && !dat_ready);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        seg_valid && seg_ready && seg_last |=> grp_done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        grp_done |=> !grp_done);

endmodule

// File: rtl/pcat_stats.sv
module pcat_stats #(
    parameter int SEG_BYTES = 64,
    parameter int FILL_W    = $clog2(SEG_BYTES + 1),
    parameter int STAT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seg_fire,
    input  logic [FILL_W-1:0] seg_pad,
    output logic [STAT_W-1:0] pad_total,
    output logic [STAT_W-1:0] fwd_total
);
    logic [STAT_W-1:0] pad_q, fwd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_q <= '0;
            fwd_q <= '0;
        end else if (seg_fire) begin
            pad_q <= pad_q + STAT_W'(seg_pad);
            fwd_q <= fwd_q + STAT_W'(SEG_BYTES);
        end
    end

    assign pad_total = pad_q;
    assign fwd_total = fwd_q;

    // R9
    fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
        seg_fire |=> fwd_total == $past(fwd_total) + STAT_W'(SEG_BYTES));

    // R9
    pad_below_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        pad_total <= fwd_total);

endmodule

// File: rtl/pcat_segmenter.sv
module pcat_segmenter #(
    parameter int SEG_BYTES = 64,
    parameter int LEN_W     = 11,
    parameter int CNT_W     = 4,
    parameter int STAT_W    = 32,
    localparam int FILL_W   = $clog2(SEG_BYTES + 1),
    localparam int GSEG_W   = $clog2(((2**CNT_W - 1) * (2**LEN_W - 1)) / SEG_BYTES + 2)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W-1:0]       cfg_max_pkts,
    input  logic                   hdr_valid,
    input  logic [LEN_W-1:0]       hdr_len,
    output logic                   hdr_ready,
    input  logic                   dat_valid,
    input  logic [7:0]             dat_byte,
    output logic                   dat_ready,
    output logic                   seg_valid,
    output logic [SEG_BYTES*8-1:0] seg_data,
    output logic                   seg_last,
    output logic [FILL_W-1:0]      seg_pad,
    input  logic                   seg_ready,
    output logic                   grp_done,
    output logic [GSEG_W-1:0]      grp_segs,
    output logic [CNT_W-1:0]       grp_pkts,
    output logic [STAT_W-1:0]      pad_total,
    output logic [STAT_W-1:0]      fwd_total
);
    logic              wr_en, clr;
    logic [FILL_W-1:0] fill;

    pcat_seg_buf #(.SEG_BYTES(SEG_BYTES), .FILL_W(FILL_W)) u_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(dat_byte),
        .clr(clr), .fill(fill), .data(seg_data)
    );

    pcat_grp_ctrl #(
        .SEG_BYTES(SEG_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W),
        .FILL_W(FILL_W), .GSEG_W(GSEG_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cfg_max_pkts(cfg_max_pkts),
        .hdr_valid(hdr_valid), .hdr_len(hdr_len), .hdr_ready(hdr_ready),
        .dat_valid(dat_valid), .dat_ready(dat_ready),
        .fill(fill), .wr_en(wr_en), .clr(clr),
        .seg_valid(seg_valid), .seg_last(seg_last), .seg_pad(seg_pad),
        .seg_ready(seg_ready), .grp_done(grp_done),
        .grp_segs(grp_segs), .grp_pkts(grp_pkts)
    );

    pcat_stats #(.SEG_BYTES(SEG_BYTES), .FILL_W(FILL_W), .STAT_W(STAT_W)) u_stats (
        .clk(clk), .rst(rst), .seg_fire(clr), .seg_pad(seg_pad),
        .pad_total(pad_total), .fwd_total(fwd_total)
    );

endmodule

// File: tb/pcat_segmenter_tb_top.sv
module pcat_segmenter_tb_top;
    localparam int SEG = 64;
    localparam int LW  = 11;
    localparam int CW  = 4;
    localparam int SW  = 32;
    localparam int FW  = $clog2(SEG + 1);
    localparam int GW  = $clog2(((2**CW - 1) * (2**LW - 1)) / SEG + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0] cfg_max_pkts = '0;
    logic hdr_valid = 1'b0;
    logic [LW-1:0] hdr_len = '0;
    logic hdr_ready;
    logic dat_valid = 1'b0;
    logic [7:0] dat_byte = '0;
    logic dat_ready;
    logic seg_valid;
    logic [SEG*8-1:0] seg_data;
    logic seg_last;
    logic [FW-1:0] seg_pad;
    logic seg_ready = 1'b0;
    logic grp_done;
    logic [GW-1:0] grp_segs;
    logic [CW-1:0] grp_pkts;
    logic [SW-1:0] pad_total, fwd_total;

    always #2 clk = ~clk;

    pcat_segmenter dut_i (
        .clk(clk), .rst(rst), .cfg_max_pkts(cfg_max_pkts),
        .hdr_valid(hdr_valid), .hdr_len(hdr_len), .hdr_ready(hdr_ready),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
        .seg_valid(seg_valid), .seg_data(seg_data), .seg_last(seg_last),
        .seg_pad(seg_pad), .seg_ready(seg_ready), .grp_done(grp_done),
        .grp_segs(grp_segs), .grp_pkts(grp_pkts),
        .pad_total(pad_total), .fwd_total(fwd_total)
    );

    int n_chk = 0;
    int n_err = 0;
    int plen [0:255];
    int base = 0;
    longint exp_pad = 0;
    longint exp_fwd = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input int p, input int j);
        return 8'((p * 37 + j * 5 + 1) & 255);
    endfunction

    task automatic run_scn(input int c, input int n, input bit gap, input bit bp,
                           input string preq, output int tsegs, output int tpad);
        int gs [0:63];
        int gc [0:63];
        int gt [0:63];
        int ng, ce, hidx, dpk, dbyte, posted, g, s, cyc;
        bit exp_done, hold, hf, df, sf;
        logic [SEG*8-1:0] hold_data, exp_v;
        ce = (c == 0) ? 1 : c;
        ng = 0;
        for (int p = 0; p < n; p += (gap ? 1 : ce)) begin
            gs[ng] = p;
            gc[ng] = gap ? 1 : ((n - p < ce) ? n - p : ce);
            gt[ng] = 0;
            for (int q = 0; q < gc[ng]; q++) gt[ng] += plen[base + p + q];
            ng++;
        end
        tsegs = 0; tpad = 0;
        cfg_max_pkts = CW'(c);
        hidx = 0; dpk = 0; dbyte = 0; g = 0; s = 0; cyc = 0;
        posted = gap ? 1 : n;
        exp_done = 0; hold = 0; hold_data = '0;
        while (g < ng || exp_done) begin
            @(negedge clk);
            hdr_valid = (hidx < posted) && (hidx < n);
            hdr_len   = LW'((hidx < n) ? plen[base + hidx] : 0);
            dat_valid = (dpk < n) && !(bp && (cyc % 5 == 2));
            dat_byte  = (dpk < n) ? pbyte(base + dpk, dbyte) : 8'h00;
            seg_ready = !(bp && (cyc % 3 == 0));
            #1;
            // R8: report one cycle after final handshake
            chk(grp_done == exp_done, "R8", "grp_done timing", grp_done, exp_done);
            if (exp_done && grp_done) begin
                chk(int'(grp_segs) == (gt[g-1] + SEG - 1) / SEG, "R2", "group segments",
                    grp_segs, (gt[g-1] + SEG - 1) / SEG);
                chk(int'(grp_pkts) == gc[g-1], preq, "group packets", grp_pkts, gc[g-1]);
            end
            exp_done = 0;
            if (hold) begin
                // R7: held segment unchanged
                chk(seg_valid && seg_data == hold_data, "R7", "held segment stable",
                    seg_valid, 1);
            end
            hf = hdr_valid && hdr_ready;
            df = dat_valid && dat_ready;
            sf = seg_valid && seg_ready;
            hold = seg_valid && !seg_ready;
            hold_data = seg_data;
            if (sf) begin
                int tot, segs_g, first_bad;
                tot = gt[g];
                segs_g = (tot + SEG - 1) / SEG;
                exp_v = '0;
                for (int k = 0; k < SEG; k++) begin
                    int gb;
                    gb = s * SEG + k;
                    if (gb < tot) begin
                        int r, p;
                        r = gb; p = gs[g];
                        while (r >= plen[base + p]) begin
                            r -= plen[base + p];
                            p++;
                        end
                        exp_v[k*8 +: 8] = pbyte(base + p, r);
                    end
                end
                first_bad = -1;
                for (int k = SEG - 1; k >= 0; k--)
                    if (seg_data[k*8 +: 8] != exp_v[k*8 +: 8]) first_bad = k;
                // R1: byte order and content, zero padding lanes
                chk(first_bad < 0, "R1", "segment byte",
                    (first_bad < 0) ? 0 : seg_data[first_bad*8 +: 8],
                    (first_bad < 0) ? 0 : exp_v[first_bad*8 +: 8]);
                // R3: last flag and padding count
                chk(seg_last == (s == segs_g - 1), "R3", "seg_last", seg_last, s == segs_g - 1);
                chk(int'(seg_pad) == ((s == segs_g - 1) ? segs_g * SEG - tot : 0), "R3",
                    "seg_pad", seg_pad, (s == segs_g - 1) ? segs_g * SEG - tot : 0);
                tsegs++;
                tpad += int'(seg_pad);
                if (s == segs_g - 1) begin
                    exp_done = 1;
                    g++;
                    s = 0;
                    if (gap) posted++;
                end else begin
                    s++;
                end
            end
            @(posedge clk);
            if (hf) hidx++;
            if (df) begin
                dbyte++;
                if (dbyte == plen[base + dpk]) begin
                    dpk++;
                    dbyte = 0;
                end
            end
            cyc++;
            if (cyc > 40000) begin
                chk(0, "R2", "watchdog expired", cyc, 0);
                break;
            end
        end
        @(negedge clk);
        hdr_valid = 0; dat_valid = 0; seg_ready = 0;
        for (int i = 0; i < ng; i++) begin
            int sg;
            sg = (gt[i] + SEG - 1) / SEG;
            exp_fwd += sg * SEG;
            exp_pad += sg * SEG - gt[i];
        end
        #1;
        // R9: cumulative counters
        chk(longint'(fwd_total) == exp_fwd, "R9", "fwd_total", fwd_total, exp_fwd);
        chk(longint'(pad_total) == exp_pad, "R9", "pad_total", pad_total, exp_pad);
        base += n;
    endtask

    initial begin
        int ts, tp;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R10: reset state
        chk(seg_valid == 0, "R10", "seg_valid after reset", seg_valid, 0);
        chk(dat_ready == 0, "R10", "dat_ready after reset", dat_ready, 0);
        chk(grp_done == 0, "R10", "grp_done after reset", grp_done, 0);
        chk(pad_total == 0 && fwd_total == 0, "R10", "totals after reset",
            pad_total + fwd_total, 0);

        // R6: joined pair
        plen[base] = 80; plen[base + 1] = 150;
        run_scn(2, 2, 0, 0, "R4", ts, tp);
        chk(ts == 4, "R6", "joined segments", ts, 4);
        chk(tp == 26, "R6", "joined padding", tp, 26);

        // R6: per-packet padding
        plen[base] = 80; plen[base + 1] = 150;
        run_scn(1, 2, 0, 0, "R4", ts, tp);
        chk(ts == 5, "R6", "separate segments", ts, 5);
        chk(tp == 90, "R6", "separate padding", tp, 90);

        // R4: threshold 0 acts as 1
        plen[base] = 100; plen[base + 1] = 64; plen[base + 2] = 40;
        run_scn(0, 3, 0, 0, "R4", ts, tp);
        chk(ts == 4, "R4", "zero threshold segments", ts, 4);

        // R3: exact segment boundaries, no padding
        plen[base] = 64; plen[base + 1] = 128;
        run_scn(2, 2, 0, 0, "R4", ts, tp);
        chk(tp == 0, "R3", "boundary padding", tp, 0);

        // R7: backpressure and input gaps, cap of 3 with more waiting
        plen[base] = 40;  plen[base + 1] = 88;  plen[base + 2] = 64;
        plen[base + 3] = 1500; plen[base + 4] = 100; plen[base + 5] = 41;
        plen[base + 6] = 127;
        run_scn(3, 7, 0, 1, "R4", ts, tp);

        // R2: sweep of thresholds and length mixes
        for (int c = 1; c <= 5; c++) begin
            for (int k = 0; k < 6; k++) plen[base + k] = 40 + 23 * k + 9 * c;
            run_scn(c, 6, 0, (c % 2) == 0, "R4", ts, tp);
        end

        // R5: queue empty at each packet boundary closes the group
        plen[base] = 90; plen[base + 1] = 200; plen[base + 2] = 45; plen[base + 3] = 64;
        run_scn(4, 4, 1, 0, "R5", ts, tp);
        chk(ts == 2 + 4 + 1 + 1, "R5", "per-packet groups when queue empty", ts, 8);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule